// File: doc/BRIEF.md
# Predictive line-buffer fetch steering

This block is the instruction-fetch front end that sits between a fetch-address generator and a direct-mapped L1 instruction cache. It keeps one whole cache line in a local line buffer. It also decides, one fetch ahead, whether the next instruction word should be read from that buffer or from L1. Because the choice is made in advance, a correct prediction costs one cycle from either source, and there is never a probe-then-miss cycle in front of an L1 read.

The steering rule uses the branch-target-buffer result for the instruction being fetched and the word position of its address within the line. A predicted-taken control transfer sends the next fetch to L1. So does a fetch of the final word of a line. Every other fetch is followed by a line-buffer fetch. Reset and a redirect from downstream also force the next fetch to L1. A line-buffer fetch whose stored line does not cover the address is caught by a tag compare, and the block then reissues that fetch to L1 on its own in the following cycle. Two counters record how many fetches went to each source.

Top module: `plb_fetch`

## Requirements
- R1: While reset is high and in the first cycle after it, instr_valid and recover are 0 and both access counters read 0. The first accepted fetch after reset is read from L1 (l1_rd_en high in that same cycle).
- R2: Every L1 read loads the whole addressed line into the line buffer. A later line-buffer fetch of any word of that line returns the same word that L1 holds.
- R3: When an accepted fetch has btb_hit and btb_taken both high, the next accepted fetch is read from L1. When btb_hit is high and btb_taken is low, the next fetch is steered exactly as it would be without a hit.
- R4: When an accepted fetch addresses the last word of its line (fetch_pc[4:2] == 7 with the default 32-byte line of 32-bit words), the next accepted fetch is read from L1. Otherwise, when no R3 or R6 condition applies, the next fetch is read from the line buffer.
- R5: instr, instr_valid and instr_src are registered and appear in the cycle after the fetch is accepted. instr_src is 0 for an L1 read and 1 for a line-buffer read.
- R6: A redirect pulse, with or without a fetch in the same cycle, forces the next accepted fetch to L1 and marks the buffered line stale.
- R7: A line-buffer fetch whose line is stale or whose tag (fetch_pc[31:5]) differs from the buffered tag gives instr_valid 0, instr_src 1 and recover 1 in the next cycle. In that recover cycle the block reads L1 at the missed address (l1_rd_tag equal to its tag) and ignores the fetch inputs. The missed word appears with instr_valid 1 and instr_src 0 one cycle later.
- R8: lb_access_cnt counts line-buffer fetch attempts, including those that miss. l1_access_cnt counts L1 reads, including reissues. Each count is visible in the cycle after the access.
- R9: Cycles with fetch_valid low produce instr_valid 0. They change neither the steering choice nor the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_pc | input | ADDR_W | Byte address of the instruction to fetch |
| btb_hit | input | 1 | BTB reports the fetched instruction as a control transfer |
| btb_taken | input | 1 | BTB predicts that control transfer taken |
| redirect | input | 1 | Downstream correction: force the next fetch to L1, line buffer stale |
| l1_rd_en | output | 1 | L1 line read this cycle |
| l1_rd_tag | output | ADDR_W-5 | Line address of the L1 read |
| l1_rd_line | input | 8*WORD_W | Line returned by L1 in the same cycle |
| instr | output | WORD_W | Fetched instruction word |
| instr_valid | output | 1 | instr holds a fetched word |
| instr_src | output | 1 | Source of the word: 0 L1, 1 line buffer |
| recover | output | 1 | Line-buffer miss being reissued to L1; fetch inputs ignored this cycle |
| lb_access_cnt | output | CNT_W | Line-buffer fetch attempts |
| l1_access_cnt | output | CNT_W | L1 reads |

## Verification
The L1 read request and its line address are combinational, so the bench checks them one nanosecond after it drives a fetch, in the same cycle. The instruction word, its valid flag, its source bit and the recover flag are due one clock edge later, and the bench samples them on the following falling edge. A line-buffer miss spreads over three cycles: the attempt, the recover cycle with its L1 reissue, and the recovered word. The stimulus table lists each of these cycles as its own row with its own expectations. The counters are compared with totals the bench builds from the table's L1 and line-buffer rows.

// File: rtl/plb_pkg.sv
package plb_pkg;
  typedef enum logic {
    SRC_L1 = 1'b0,
    SRC_LB = 1'b1
  } fetch_src_e;
endpackage

// File: rtl/plb_steer.sv
// Next-fetch source prediction from the current fetch's BTB result and word offset.
module plb_steer #(
  parameter int OFF_W = 3
) (
  input  logic [OFF_W-1:0] word_off,
  input  logic             btb_hit,
  input  logic             btb_taken,
  output logic             next_from_lb
);
  logic taken_xfer;
  logic line_end;

  assign taken_xfer   = btb_hit & btb_taken;
  assign line_end     = &word_off;
  assign next_from_lb = ~taken_xfer & ~line_end;
endmodule

// File: rtl/plb_line_buf.sv
// Single-line buffer: line storage, tag, valid, and word read port.
module plb_line_buf #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int TAG_W      = 27,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic [LINE_W-1:0] load_line,
  input  logic              invalidate,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [OFF_W-1:0]  rd_off,
  output logic              hit,
  output logic [WORD_W-1:0] rd_word
);
  logic [LINE_W-1:0] line_q;
  logic [TAG_W-1:0]  tag_q;
  logic              valid_q;
  logic [WORD_W-1:0] words [LINE_WORDS];

  // data and tag carry no reset; only the valid bit does
  always_ff @(posedge clk) begin
    if (load) begin
      line_q <= load_line;
      tag_q  <= load_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             valid_q <= 1'b0;
    else if (invalidate) valid_q <= 1'b0;
    else if (load)       valid_q <= 1'b1;
  end

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
    assign words[g] = line_q[g*WORD_W +: WORD_W];
  end

  assign rd_word = words[rd_off];
  assign hit     = valid_q & (tag_q == rd_tag);
endmodule

// File: rtl/plb_counter.sv
module plb_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/plb_fetch.sv
module plb_fetch
  import plb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int CNT_W      = 16,
  localparam int BYTE_OFF  = $clog2(WORD_W / 8),
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int WA_W      = ADDR_W - BYTE_OFF,
  localparam int TAG_W     = WA_W - OFF_W,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              btb_hit,
  input  logic              btb_taken,
  input  logic              redirect,
  output logic              l1_rd_en,
  output logic [TAG_W-1:0]  l1_rd_tag,
  input  logic [LINE_W-1:0] l1_rd_line,
  output logic [WORD_W-1:0] instr,
  output logic              instr_valid,
  output logic              instr_src,
  output logic              recover,
  output logic [CNT_W-1:0]  lb_access_cnt,
  output logic [CNT_W-1:0]  l1_access_cnt
);
  logic [WA_W-1:0]     pc_wa;
  logic [BYTE_OFF-1:0] unused_pc_bits;
  logic [WA_W-1:0]     held_wa_q;
  logic [WA_W-1:0]     l1_wa;
  logic                use_lb_q;
  logic                recover_q;
  logic                accept;
  logic                lb_try;
  logic                l1_go;
  logic                lb_hit;
  logic                next_from_lb;
  logic [WORD_W-1:0]   lb_word;
  logic [WORD_W-1:0]   l1_word;
  logic [WORD_W-1:0]   l1_words [LINE_WORDS];

  assign pc_wa          = fetch_pc[ADDR_W-1:BYTE_OFF];
  assign unused_pc_bits = fetch_pc[BYTE_OFF-1:0];

  // A recover cycle belongs to the reissue; fetch inputs are not accepted.
  assign accept = fetch_valid & ~recover_q;
  assign lb_try = accept & use_lb_q;
  assign l1_go  = recover_q | (accept & ~use_lb_q);
  assign l1_wa  = recover_q ? held_wa_q : pc_wa;

  assign l1_rd_en  = l1_go;
  assign l1_rd_tag = l1_wa[WA_W-1:OFF_W];
  assign recover   = recover_q;

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_l1_word
    assign l1_words[g] = l1_rd_line[g*WORD_W +: WORD_W];
  end
  assign l1_word = l1_words[l1_wa[OFF_W-1:0]];

  plb_line_buf #(
    .WORD_W     (WORD_W),
    .LINE_WORDS (LINE_WORDS),
    .TAG_W      (TAG_W)
  ) u_line_buf (
    .clk        (clk),
    .rst        (rst),
    .load       (l1_go),
    .load_tag   (l1_wa[WA_W-1:OFF_W]),
    .load_line  (l1_rd_line),
    .invalidate (redirect),
    .rd_tag     (pc_wa[WA_W-1:OFF_W]),
    .rd_off     (pc_wa[OFF_W-1:0]),
    .hit        (lb_hit),
    .rd_word    (lb_word)
  );

  plb_steer #(
    .OFF_W (OFF_W)
  ) u_steer (
    .word_off     (pc_wa[OFF_W-1:0]),
    .btb_hit      (btb_hit),
    .btb_taken    (btb_taken),
    .next_from_lb (next_from_lb)
  );

  plb_counter #(.CNT_W(CNT_W)) u_lb_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (lb_try),
    .count (lb_access_cnt)
  );

  plb_counter #(.CNT_W(CNT_W)) u_l1_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (l1_go),
    .count (l1_access_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      use_lb_q    <= 1'b0;
      recover_q   <= 1'b0;
      held_wa_q   <= '0;
      instr       <= '0;
      instr_valid <= 1'b0;
      instr_src   <= SRC_L1;
    end else begin
      instr_valid <= l1_go | (lb_try & lb_hit);
      instr_src   <= lb_try ? SRC_LB : SRC_L1;
      instr       <= l1_go ? l1_word : lb_word;
      recover_q   <= lb_try & ~lb_hit;
      if (lb_try) held_wa_q <= pc_wa;
      if (redirect)    use_lb_q <= 1'b0;
      else if (accept) use_lb_q <= next_from_lb;
    end
  end
endmodule

// File: rtl/plb_fetch_chk.sv
module plb_fetch_chk #(
  parameter int OFF_W = 3,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             fetch_valid,
  input logic [OFF_W-1:0] pc_off,
  input logic             btb_hit,
  input logic             btb_taken,
  input logic             redirect,
  input logic             l1_rd_en,
  input logic             instr_valid,
  input logic             instr_src,
  input logic             recover,
  input logic [CNT_W-1:0] l1_access_cnt
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!instr_valid && !recover && l1_access_cnt == '0));

  assert_taken_to_l1_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !recover && btb_hit && btb_taken)
      |=> (!fetch_valid || recover || l1_rd_en));

  assert_line_end_to_l1_R4: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !recover && (&pc_off))
      |=> (!fetch_valid || recover || l1_rd_en));

  assert_l1_result_R5: assert property (@(posedge clk) disable iff (rst)
    l1_rd_en |=> (instr_valid && !instr_src));

  assert_redirect_to_l1_R6: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (!fetch_valid || recover || l1_rd_en));

  assert_recover_no_data_R7: assert property (@(posedge clk) disable iff (rst)
    recover |-> (!instr_valid && instr_src));

  assert_recover_reissue_R7: assert property (@(posedge clk) disable iff (rst)
    recover |=> (instr_valid && !instr_src && !recover));

  assert_l1_count_R8: assert property (@(posedge clk) disable iff (rst)
    l1_rd_en |=> (l1_access_cnt == CNT_W'($past(l1_access_cnt) + 1'b1)));

  assert_idle_no_data_R9: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid && !recover) |=> !instr_valid);
endmodule

bind plb_fetch plb_fetch_chk #(
  .OFF_W (OFF_W),
  .CNT_W (CNT_W)
) u_plb_fetch_chk (
  .clk           (clk),
  .rst           (rst),
  .fetch_valid   (fetch_valid),
  .pc_off        (fetch_pc[BYTE_OFF +: OFF_W]),
  .btb_hit       (btb_hit),
  .btb_taken     (btb_taken),
  .redirect      (redirect),
  .l1_rd_en      (l1_rd_en),
  .instr_valid   (instr_valid),
  .instr_src     (instr_src),
  .recover       (recover),
  .l1_access_cnt (l1_access_cnt)
);

// File: tb/test_plb_fetch.sv
`timescale 1ns/1ps
module test_plb_fetch;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int LINE_WORDS = 8;
  localparam int CNT_W = 16;
  localparam int TAG_W = ADDR_W - 5;
  localparam int LINE_W = WORD_W * LINE_WORDS;
  localparam int NV = 20;

  typedef struct packed {
    logic        v;
    logic [31:0] pc;
    logic        hit;
    logic        tk;
    logic        rd;
    logic        el1;  // L1 read expected this cycle
    logic        ev;   // instr_valid expected next cycle
    logic        es;   // instr_src expected next cycle
    logic        er;   // recover expected next cycle
    logic [31:0] epc;  // address whose word is expected
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h1000, 4'd1},
    '{1'b1, 32'h1004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h1004, 4'd2},
    '{1'b1, 32'h1008, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h1008, 4'd5},
    '{1'b1, 32'h100C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h100C, 4'd3},
    '{1'b1, 32'h2010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h2010, 4'd3},
    '{1'b1, 32'h2014, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h2014, 4'd2},
    '{1'b0, 32'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000, 4'd9},
    '{1'b1, 32'h2018, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h2018, 4'd9},
    '{1'b1, 32'h201C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h201C, 4'd4},
    '{1'b1, 32'h2020, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h2020, 4'd4},
    '{1'b1, 32'h2024, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h2024, 4'd6},
    '{1'b1, 32'h3000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h3000, 4'd6},
    '{1'b1, 32'h3004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h3004, 4'd2},
    '{1'b1, 32'h5008, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h5008, 4'd7},
    '{1'b1, 32'hDEAD_BEE0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h5008, 4'd7},
    '{1'b1, 32'h500C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h500C, 4'd2},
    '{1'b0, 32'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000, 4'd6},
    '{1'b1, 32'h5010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h5010, 4'd6},
    '{1'b1, 32'h501C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h501C, 4'd4},
    '{1'b1, 32'h5020, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h5020, 4'd4}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              fetch_valid = 1'b0;
  logic [ADDR_W-1:0] fetch_pc = '0;
  logic              btb_hit = 1'b0;
  logic              btb_taken = 1'b0;
  logic              redirect = 1'b0;
  logic              l1_rd_en;
  logic [TAG_W-1:0]  l1_rd_tag;
  logic [LINE_W-1:0] l1_rd_line;
  logic [WORD_W-1:0] instr;
  logic              instr_valid;
  logic              instr_src;
  logic              recover;
  logic [CNT_W-1:0]  lb_access_cnt;
  logic [CNT_W-1:0]  l1_access_cnt;

  int checks = 0;
  int errors = 0;
  int exp_lb = 0;
  int exp_l1 = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_F00F;
  endfunction

  // behavioural L1: same-cycle line read
  always_comb begin
    for (int w = 0; w < LINE_WORDS; w++)
      l1_rd_line[w*WORD_W +: WORD_W] = mem_word({l1_rd_tag, 3'(w), 2'b00});
  end

  plb_fetch i_plb_fetch (
    .clk (clk), .rst (rst), .fetch_valid (fetch_valid), .fetch_pc (fetch_pc),
    .btb_hit (btb_hit), .btb_taken (btb_taken), .redirect (redirect),
    .l1_rd_en (l1_rd_en), .l1_rd_tag (l1_rd_tag), .l1_rd_line (l1_rd_line),
    .instr (instr), .instr_valid (instr_valid), .instr_src (instr_src),
    .recover (recover), .lb_access_cnt (lb_access_cnt), .l1_access_cnt (l1_access_cnt)
  );

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs while in reset
    check("R1", "valid in reset", 32'(instr_valid), 32'd0);
    check("R1", "recover in reset", 32'(recover), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "lb count after reset", 32'(lb_access_cnt), 32'd0);
    check("R1", "l1 count after reset", 32'(l1_access_cnt), 32'd0);

    for (int i = 0; i < NV; i++) begin
      fetch_valid = VECS[i].v;
      fetch_pc    = VECS[i].pc;
      btb_hit     = VECS[i].hit;
      btb_taken   = VECS[i].tk;
      redirect    = VECS[i].rd;
      #1;
      check(req_name(VECS[i].req), "l1_rd_en", 32'(l1_rd_en), 32'(VECS[i].el1));
      if (VECS[i].el1)
        check(req_name(VECS[i].req), "l1_rd_tag", 32'(l1_rd_tag), 32'(VECS[i].epc[31:5]));
      if (VECS[i].el1) exp_l1++;
      else if (VECS[i].v) exp_lb++;
      @(negedge clk);
      check(req_name(VECS[i].req), "instr_valid", 32'(instr_valid), 32'(VECS[i].ev));
      check(req_name(VECS[i].req), "recover", 32'(recover), 32'(VECS[i].er));
      if (VECS[i].ev || VECS[i].er)
        check(req_name(VECS[i].req), "instr_src", 32'(instr_src), 32'(VECS[i].es));
      if (VECS[i].ev)
        check(req_name(VECS[i].req), "instr", instr, mem_word(VECS[i].epc));
    end
    fetch_valid = 1'b0;
    redirect = 1'b0;
    @(negedge clk);
    // R8: totals from the table (idle rows count nothing, R9)
    check("R8", "lb_access_cnt", 32'(lb_access_cnt), 32'(exp_lb));
    check("R8", "l1_access_cnt", 32'(l1_access_cnt), 32'(exp_l1));

    // R1: reset mid-run clears state, first fetch goes to L1
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "valid after reset", 32'(instr_valid), 32'd0);
    check("R1", "count after reset", 32'(l1_access_cnt), 32'd0);
    fetch_valid = 1'b1;
    fetch_pc = 32'h6004;
    btb_hit = 1'b0;
    btb_taken = 1'b0;
    #1;
    check("R1", "first fetch l1", 32'(l1_rd_en), 32'd1);
    @(negedge clk);
    fetch_pc = 32'h6008;
    #1;
    check("R2", "second fetch from buffer", 32'(l1_rd_en), 32'd0);
    @(negedge clk);
    fetch_valid = 1'b0;
    check("R2", "buffer word", instr, mem_word(32'h6008));
    check("R5", "buffer source", 32'(instr_src), 32'd1);
    check("R8", "lb count", 32'(lb_access_cnt), 32'd1);
    check("R8", "l1 count", 32'(l1_access_cnt), 32'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule